// File: doc/BRIEF.md
# Two-Way Interrupting Mailbox Set

This block lets two processors on the same clock, a host and a coprocessor, exchange short messages through four hardware mailboxes. Each processor reaches the block through its own register port, which has an address, a write strobe, a read strobe, 16-bit write data and 16-bit registered read data. Every mailbox holds a data word and a command word.

Mailboxes 0 and 1 carry messages from the host to the coprocessor. Mailboxes 2 and 3 carry messages the other way. The sender writes the data word first and then the command word. The command write raises a level interrupt toward the receiver. When the receiver reads that command word, the interrupt drops. If the sender posts a second command before the first one has been taken, the block sets a sticky overflow flag for that mailbox.

Top module: `mailbox_quad`

## Requirements
- R1: After reset, `mb_irq` and `mb_ovf` are 0, both read-data outputs are 0, and every register reads back 0.
- R2: Address encoding on both ports: bits [2:1] select the mailbox and bit 0 selects the word (0 = data, 1 = command). A host write to mailbox 0 or 1 updates the selected word on the clock edge where `h_wen` is sampled high, and both ports can read it back.
- R3: Coprocessor writes to mailbox 2 or 3 work in the same way, through the coprocessor port.
- R4: A write from the side that does not own a mailbox changes neither word of that mailbox and leaves its interrupt low. The host owns mailboxes 0 and 1; the coprocessor owns mailboxes 2 and 3.
- R5: A command-word write by the owner sets `mb_irq[i]` on the same edge. A data-word write does not set it.
- R6: A read strobe presents the selected word on the read-data output one edge later. A read of the command word by the receiving side clears `mb_irq[i]` on that edge. Reading the data word does not clear it, and neither does a read by the owner.
- R7: A command write by the owner while `mb_irq[i]` is set overwrites the word, keeps the interrupt high and sets `mb_ovf[i]`. Once set, `mb_ovf[i]` stays set until reset.
- R8: If an owner command write and a clearing receiver read of the same mailbox fall in the same cycle, the following all hold:
  - the interrupt stays set;
  - `mb_ovf` is not set;
  - the reader receives the previous command word;
  - the new command word stays pending.
- R9: A synchronous active-high `rst` clears all words, interrupts, overflow flags and read-data outputs, including state that was set before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset |
| h_addr | input | 3 | Host address: mailbox in bits [2:1], word select in bit 0 |
| h_wen | input | 1 | Host write strobe |
| h_ren | input | 1 | Host read strobe |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data, valid one cycle after `h_ren` |
| c_addr | input | 3 | Coprocessor address, same encoding as the host address |
| c_wen | input | 1 | Coprocessor write strobe |
| c_ren | input | 1 | Coprocessor read strobe |
| c_wdata | input | 16 | Coprocessor write data |
| c_rdata | output | 16 | Coprocessor read data, valid one cycle after `c_ren` |
| mb_irq | output | 4 | Pending-message level per mailbox (bits 0-1 go to the coprocessor, bits 2-3 go to the host) |
| mb_ovf | output | 4 | Sticky overflow flag per mailbox |

## Verification
Each result is due exactly one edge after its stimulus:
- Stored words, `mb_irq` and `mb_ovf` all change on the edge that samples the write or read strobe.
- Read data appears on that same edge, so it can be sampled at the next falling edge.

The bench drives every strobe on a falling edge and drops it at the next falling edge. It then checks outputs at that falling edge, half a period after the edge that took effect. The same-cycle case drives both ports inside one falling-edge window. The bench then checks the returned data, the interrupt and the overflow flag together, before any further access.

// File: rtl/mailbox_quad.sv
module mailbox_quad #(
  parameter int DW   = 16,
  parameter int NBOX = 4,
  localparam int IW  = $clog2(NBOX),
  localparam int AW  = IW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] h_addr,
  input  logic          h_wen,
  input  logic          h_ren,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  input  logic [AW-1:0] c_addr,
  input  logic          c_wen,
  input  logic          c_ren,
  input  logic [DW-1:0] c_wdata,
  output logic [DW-1:0] c_rdata,
  output logic [NBOX-1:0] mb_irq,
  output logic [NBOX-1:0] mb_ovf
);

  localparam int HOST_BOXES = NBOX / 2;

  logic [DW-1:0] dat_q [NBOX];
  logic [DW-1:0] cmd_q [NBOX];
  logic [NBOX-1:0] wr_dat, wr_cmd, clr, foreign;
  logic [DW-1:0] wval [NBOX];

  always_comb begin
    for (int i = 0; i < NBOX; i++) begin
      if (i < HOST_BOXES) begin
        wr_cmd[i]  = h_wen && (h_addr[AW-1:1] == IW'(i)) && h_addr[0];
        wr_dat[i]  = h_wen && (h_addr[AW-1:1] == IW'(i)) && !h_addr[0];
        foreign[i] = c_wen && (c_addr[AW-1:1] == IW'(i));
        clr[i]     = c_ren && (c_addr[AW-1:1] == IW'(i)) && c_addr[0];
        wval[i]    = h_wdata;
      end else begin
        wr_cmd[i]  = c_wen && (c_addr[AW-1:1] == IW'(i)) && c_addr[0];
        wr_dat[i]  = c_wen && (c_addr[AW-1:1] == IW'(i)) && !c_addr[0];
        foreign[i] = h_wen && (h_addr[AW-1:1] == IW'(i));
        clr[i]     = h_ren && (h_addr[AW-1:1] == IW'(i)) && h_addr[0];
        wval[i]    = c_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBOX; i++) begin
        dat_q[i] <= '0;
        cmd_q[i] <= '0;
      end
      mb_irq  <= '0;
      mb_ovf  <= '0;
      h_rdata <= '0;
      c_rdata <= '0;
    end else begin
      for (int i = 0; i < NBOX; i++) begin
        if (wr_dat[i]) dat_q[i] <= wval[i];
        if (wr_cmd[i]) cmd_q[i] <= wval[i];
        if (wr_cmd[i])   mb_irq[i] <= 1'b1;
        else if (clr[i]) mb_irq[i] <= 1'b0;
        if (wr_cmd[i] && mb_irq[i] && !clr[i]) mb_ovf[i] <= 1'b1;
      end
      if (h_ren) h_rdata <= h_addr[0] ? cmd_q[h_addr[AW-1:1]] : dat_q[h_addr[AW-1:1]];
      if (c_ren) c_rdata <= c_addr[0] ? cmd_q[c_addr[AW-1:1]] : dat_q[c_addr[AW-1:1]];
    end
  end

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (mb_irq == '0 && mb_ovf == '0 && h_rdata == '0 && c_rdata == '0));

  for (genvar g = 0; g < NBOX; g++) begin : g_chk
    a_r5_cmd_sets_irq: assert property (@(posedge clk) disable iff (rst)
      wr_cmd[g] |=> mb_irq[g]);
    a_r5_data_keeps_irq_low: assert property (@(posedge clk) disable iff (rst)
      (wr_dat[g] && !mb_irq[g]) |=> !mb_irq[g]);
    a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
      (clr[g] && !wr_cmd[g]) |=> !mb_irq[g]);
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
      mb_ovf[g] |=> mb_ovf[g]);
    a_r7_rewrite_flags: assert property (@(posedge clk) disable iff (rst)
      (wr_cmd[g] && mb_irq[g] && !clr[g]) |=> mb_ovf[g]);
    a_r4_foreign_ignored: assert property (@(posedge clk) disable iff (rst)
      (foreign[g] && !wr_cmd[g] && !wr_dat[g]) |=> ($stable(cmd_q[g]) && $stable(dat_q[g])));
    a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
      (wr_cmd[g] && clr[g]) |=> (mb_irq[g] && mb_ovf[g] == $past(mb_ovf[g])));
  end

endmodule

// File: tb/tb_mailbox_quad.sv
module tb_mailbox_quad;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst = 1;
  logic [2:0] h_addr = 0, c_addr = 0;
  logic h_wen = 0, h_ren = 0, c_wen = 0, c_ren = 0;
  logic [15:0] h_wdata = 0, c_wdata = 0, h_rdata, c_rdata;
  logic [3:0] mb_irq, mb_ovf;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mailbox_quad dut (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); h_wen = 1; h_addr = a; h_wdata = d;
    @(negedge clk); h_wen = 0;
  endtask

  task automatic cwr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); c_wen = 1; c_addr = a; c_wdata = d;
    @(negedge clk); c_wen = 0;
  endtask

  task automatic hrd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk); h_ren = 1; h_addr = a;
    @(negedge clk); h_ren = 0; d = h_rdata;
  endtask

  task automatic crd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk); c_ren = 1; c_addr = a;
    @(negedge clk); c_ren = 0; d = c_rdata;
  endtask

  task automatic t_reset_state;
    logic [15:0] d;
    chk("R1 irq", {12'd0, mb_irq}, 16'h0);
    chk("R1 ovf", {12'd0, mb_ovf}, 16'h0);
    chk("R1 h_rdata", h_rdata, 16'h0);
    for (int a = 0; a < 8; a++) begin
      hrd(3'(a), d);
      chk("R1 register", d, 16'h0);
    end
  endtask

  task automatic t_host_to_cop;
    logic [15:0] d;
    hwr(3'b000, 16'h1234);
    chk("R5 data write no irq", {15'd0, mb_irq[0]}, 16'h0);
    hwr(3'b001, 16'hA001);
    chk("R5 cmd write irq", {15'd0, mb_irq[0]}, 16'h1);
    crd(3'b000, d);
    chk("R2 cop reads data", d, 16'h1234);
    chk("R6 data read keeps irq", {15'd0, mb_irq[0]}, 16'h1);
    hrd(3'b001, d);
    chk("R2 host reads own cmd", d, 16'hA001);
    chk("R6 owner read keeps irq", {15'd0, mb_irq[0]}, 16'h1);
    crd(3'b001, d);
    chk("R6 cop reads cmd", d, 16'hA001);
    chk("R6 receiver read clears", {15'd0, mb_irq[0]}, 16'h0);
  endtask

  task automatic t_cop_to_host;
    logic [15:0] d;
    cwr(3'b110, 16'h5A5A);
    cwr(3'b111, 16'hC003);
    chk("R3 irq to host", {12'd0, mb_irq}, 16'h8);
    hrd(3'b110, d);
    chk("R3 host reads data", d, 16'h5A5A);
    crd(3'b111, d);
    chk("R3 cop reads own cmd", d, 16'hC003);
    chk("R6 owner read keeps irq3", {15'd0, mb_irq[3]}, 16'h1);
    hrd(3'b111, d);
    chk("R3 host reads cmd", d, 16'hC003);
    chk("R6 host read clears irq3", {15'd0, mb_irq[3]}, 16'h0);
  endtask

  task automatic t_foreign;
    logic [15:0] d;
    cwr(3'b011, 16'hDEAD);
    cwr(3'b010, 16'hBEEF);
    chk("R4 no irq from foreign write", {12'd0, mb_irq}, 16'h0);
    hrd(3'b011, d);
    chk("R4 cmd1 unchanged", d, 16'h0);
    hrd(3'b010, d);
    chk("R4 data1 unchanged", d, 16'h0);
    hwr(3'b100, 16'h7777);
    hwr(3'b101, 16'h6666);
    chk("R4 no irq2", {12'd0, mb_irq}, 16'h0);
    crd(3'b100, d);
    chk("R4 data2 unchanged", d, 16'h0);
    crd(3'b101, d);
    chk("R4 cmd2 unchanged", d, 16'h0);
  endtask

  task automatic t_overflow;
    logic [15:0] d;
    hwr(3'b011, 16'h0011);
    chk("R7 no ovf first", {12'd0, mb_ovf}, 16'h0);
    hwr(3'b011, 16'h0022);
    chk("R7 irq kept", {15'd0, mb_irq[1]}, 16'h1);
    chk("R7 ovf set", {12'd0, mb_ovf}, 16'h2);
    crd(3'b011, d);
    chk("R7 overwritten", d, 16'h0022);
    chk("R7 irq cleared", {15'd0, mb_irq[1]}, 16'h0);
    chk("R7 ovf sticky", {12'd0, mb_ovf}, 16'h2);
  endtask

  task automatic t_collision;
    logic [15:0] d;
    hwr(3'b001, 16'h0100);
    @(negedge clk);
    h_wen = 1; h_addr = 3'b001; h_wdata = 16'h0200;
    c_ren = 1; c_addr = 3'b001;
    @(negedge clk);
    h_wen = 0; c_ren = 0;
    chk("R8 reader gets old", c_rdata, 16'h0100);
    chk("R8 irq stays", {15'd0, mb_irq[0]}, 16'h1);
    chk("R8 no ovf", {15'd0, mb_ovf[0]}, 16'h0);
    crd(3'b001, d);
    chk("R8 new word pending", d, 16'h0200);
    chk("R8 then cleared", {15'd0, mb_irq[0]}, 16'h0);
  endtask

  task automatic t_reset_again;
    logic [15:0] d;
    cwr(3'b101, 16'h4444);
    cwr(3'b101, 16'h4445);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R9 irq cleared", {12'd0, mb_irq}, 16'h0);
    chk("R9 ovf cleared", {12'd0, mb_ovf}, 16'h0);
    hrd(3'b101, d);
    chk("R9 cmd cleared", d, 16'h0);
    hrd(3'b000, d);
    chk("R9 data cleared", d, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset_state();
    t_host_to_cop();
    t_cop_to_host();
    t_foreign();
    t_overflow();
    t_collision();
    t_reset_again();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule